// File: doc/BRIEF.md
# Indexed Global Configuration Register with Scratchpad Window Decode

This block gives software access to one 8-bit global configuration register through a pair of I/O ports: a write to the index port picks a register, and later accesses to the data port read or write it. Only one index is implemented. Any other selected index reads as zero and ignores writes. The register keeps two fields. A 2-bit window code places a memory-mapped control window at one of three fixed bases in the top three quarters of the 32-bit physical space, or turns the window off. A 2-bit size code reserves 0, 2, 3 or 4 KB of scratchpad at the top end of the first 4 KB page of that window.

The block applies these settings to a 32-bit physical address input. It raises one flag when the address falls in the control window and another when it falls in the scratchpad part of it. It also drives the size code and a window enable for the rest of the chip. A small two-state machine records whether the index last written is the configuration register's index. The I/O handshake is a single-cycle read or write strobe. Read data is combinational in the strobe cycle, and register writes take effect at the clock edge that ends the strobe.

Top module: `gcfg_window`

## Requirements
- R1: After reset the configuration register is 0x00, `sp_size` is 0, `win_en` is 0, both hit flags are 0, and a data-port read returns 0x00.
- R2: A write to port 0x0022 selects a register index. While index 0xB8 is selected, a write to port 0x0023 loads data bits [3:0] into the register, and a read of port 0x0023 returns the register value.
- R3: Bits [7:4] of the register ignore writes and always read as 0.
- R4: While any index other than 0xB8 is selected, data-port reads return 0x00 and data-port writes leave the register, `sp_size` and `win_en` unchanged.
- R5: The selected index persists across any number of data-port reads and writes until the index port is written again.
- R6: A read of port 0x0022 returns 0x00. Strobes to any port other than 0x0022 and 0x0023 change nothing, and their reads return 0x00.
- R7: Register bits [1:0] select the window base: 0 disables the window, 1 gives 0x40000000, 2 gives 0x80000000, and 3 gives 0xC0000000. `win_hit` is 1 exactly when the window is enabled and the address lies in [base, base + 2^WIN_SPAN_LOG2). The default span is 16 MB.
- R8: `sp_hit` is 1 exactly when the window is enabled, register bits [3:2] are nonzero, and the address lies in [base + 4096 − S, base + 4095]. S is 2048, 3072 or 4096 bytes for codes 1, 2 and 3.
- R9: `sp_size` always equals register bits [3:2]. `win_en` is 1 exactly when register bits [1:0] are nonzero.
- R10: A read-modify-write that reads the register, ORs in 0x0C and writes the result back sets the size code to 3 and keeps the window code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_port | input | 16 | I/O port address of the current strobe |
| io_wr | input | 1 | Single-cycle I/O write strobe |
| io_rd | input | 1 | Single-cycle I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, valid during the read strobe |
| mem_addr | input | 32 | Physical address to decode |
| sp_hit | output | 1 | Address lies in the scratchpad region |
| win_hit | output | 1 | Address lies in the control window |
| sp_size | output | 2 | Scratchpad size code |
| win_en | output | 1 | Control window enabled |

## Verification
The assertions check on every cycle that the reserved read bits are zero, that a scratchpad hit always implies a window hit and a nonzero size, that no hit occurs while the window is disabled, and that strobes to foreign ports leave the outputs stable. Whether the index selection persists, whether writes to a foreign index are ignored, and whether the decoded boundaries sit at the exact byte offsets for every combination of size and base can only be shown by the bench's scenarios. The bench covers these by sweeping all 16 values of the writable field and probing each window edge and scratchpad edge.

// File: rtl/gcfg_pkg.sv
package gcfg_pkg;
    localparam logic [15:0] INDEX_PORT = 16'h0022;
    localparam logic [15:0] DATA_PORT  = 16'h0023;
    localparam logic [7:0]  CFG_INDEX  = 8'hB8;
    localparam int          CFG_BITS   = 4;

    typedef enum logic {
        SEL_OTHER = 1'b0,
        SEL_CFG   = 1'b1
    } sel_state_e;

    typedef struct packed {
        logic [1:0] sp_code;
        logic [1:0] win_code;
    } cfg_fields_t;
endpackage

// File: rtl/gcfg_regs.sv
module gcfg_regs
    import gcfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] io_port,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    output cfg_fields_t cfg
);
    sel_state_e state_q, state_d;
    cfg_fields_t cfg_q;

    wire idx_wr  = io_wr && (io_port == INDEX_PORT);
    wire data_wr = io_wr && (io_port == DATA_PORT);
    wire data_rd = io_rd && (io_port == DATA_PORT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEL_OTHER;
        else        state_q <= state_d;
    end

    // transitions: SEL_OTHER <-> SEL_CFG on index-port writes only
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_OTHER: if (idx_wr && io_wdata == CFG_INDEX) state_d = SEL_CFG;
            SEL_CFG:   if (idx_wr && io_wdata != CFG_INDEX) state_d = SEL_OTHER;
            default:   state_d = SEL_OTHER;
        endcase
    end

    // configuration register: only the low field is storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (data_wr && state_q == SEL_CFG)
            cfg_q <= cfg_fields_t'(io_wdata[CFG_BITS-1:0]);
    end

    // output process
    always_comb begin
        io_rdata = 8'h00;
        unique case (state_q)
            SEL_CFG:   if (data_rd) io_rdata = {{(8-CFG_BITS){1'b0}}, cfg_q};
            SEL_OTHER: io_rdata = 8'h00;
            default:   io_rdata = 8'h00;
        endcase
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/gcfg_decode.sv
module gcfg_decode
    import gcfg_pkg::*;
#(
    parameter int WIN_SPAN_LOG2 = 24,
    parameter int PAGE_LOG2     = 12
) (
    input  cfg_fields_t cfg,
    input  logic [31:0] mem_addr,
    output logic        win_hit,
    output logic        sp_hit
);
    localparam int KB_LOG2 = 10;

    logic [29:0]          win_off;
    logic [PAGE_LOG2-1:0] page_off;
    logic [PAGE_LOG2-1:0] sp_floor;
    logic                 in_page;

    always_comb begin
        win_off  = mem_addr[29:0];
        page_off = mem_addr[PAGE_LOG2-1:0];
        win_hit  = (cfg.win_code != 2'd0) && (mem_addr[31:30] == cfg.win_code)
                   && ((win_off >> WIN_SPAN_LOG2) == 30'd0);
        in_page  = win_hit && ((win_off >> PAGE_LOG2) == 30'd0);
        // region size is (code+1) KB, so its floor is (3-code) KB
        sp_floor = PAGE_LOG2'({2'd3 - cfg.sp_code}) << KB_LOG2;
        sp_hit   = in_page && (cfg.sp_code != 2'd0) && (page_off >= sp_floor);
    end
endmodule

// File: rtl/gcfg_window.sv
module gcfg_window
    import gcfg_pkg::*;
#(
    parameter int WIN_SPAN_LOG2 = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] io_port,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    input  logic [31:0] mem_addr,
    output logic        sp_hit,
    output logic        win_hit,
    output logic [1:0]  sp_size,
    output logic        win_en
);
    cfg_fields_t cfg;

    gcfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .io_port(io_port), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg(cfg)
    );

    gcfg_decode #(.WIN_SPAN_LOG2(WIN_SPAN_LOG2)) u_dec (
        .cfg(cfg), .mem_addr(mem_addr), .win_hit(win_hit), .sp_hit(sp_hit)
    );

    assign sp_size = cfg.sp_code;
    assign win_en  = (cfg.win_code != 2'd0);
endmodule

// File: rtl/gcfg_window_chk.sv
module gcfg_window_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_port,
    input logic        io_wr,
    input logic        io_rd,
    input logic [7:0]  io_rdata,
    input logic        sp_hit,
    input logic        win_hit,
    input logic [1:0]  sp_size,
    input logic        win_en
);
    wire foreign = (io_wr || io_rd) && io_port != 16'h0022 && io_port != 16'h0023;

    assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata[7:4] == 4'h0);
    assert_sp_in_win_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sp_hit |-> (win_hit && sp_size != 2'd0));
    assert_no_hit_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |-> (!win_hit && !sp_hit));
    assert_foreign_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        foreign |=> ($stable(sp_size) && $stable(win_en)));
    assert_foreign_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_port != 16'h0023) |-> io_rdata == 8'h00);
endmodule

bind gcfg_window gcfg_window_chk u_chk (
    .clk(clk), .rst_n(rst_n), .io_port(io_port), .io_wr(io_wr), .io_rd(io_rd),
    .io_rdata(io_rdata), .sp_hit(sp_hit), .win_hit(win_hit),
    .sp_size(sp_size), .win_en(win_en)
);

// File: tb/sim_gcfg_window.sv
`timescale 1ns/1ps
module sim_gcfg_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_port = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [31:0] mem_addr = '0;
    logic        sp_hit, win_hit, win_en;
    logic [1:0]  sp_size;

    int tests = 0, fails = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    gcfg_window u0 (.*);

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] p, input logic [7:0] d);
        @(negedge clk);
        io_port = p; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] p, output logic [7:0] d);
        @(negedge clk);
        io_port = p; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    function automatic logic exp_win(input logic [1:0] wc, input logic [31:0] a);
        return wc != 0 && a[31:30] == wc && a[29:0] < 30'(1 << 24);
    endfunction

    function automatic logic exp_sp(input logic [3:0] v, input logic [31:0] a);
        int sz;
        sz = (v[3:2] + 1) * 1024;
        return exp_win(v[1:0], a) && v[3:2] != 0 && a[29:0] < 4096
               && int'(a[11:0]) >= 4096 - sz;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sp_size", sp_size, 0);
        chk("R1 win_en", win_en, 0);
        mem_addr = 32'h4000_0FFF; #1;
        chk("R1 hits", {sp_hit, win_hit}, 0);
        io_write(16'h0022, 8'hB8);
        io_read(16'h0023, rd);
        chk("R1 cfg read", rd, 8'h00);

        // R2/R3/R9/R7/R8 sweep of all writable values
        for (int v = 0; v < 16; v++) begin
            logic [31:0] base;
            logic [7:0] wv;
            wv = 8'(v) | 8'hA0;
            io_write(16'h0023, wv);
            io_read(16'h0023, rd);
            chk("R2/R3 readback", rd, 32'(v));
            chk("R9 sp_size", sp_size, 32'(v >> 2));
            chk("R9 win_en", win_en, 32'((v & 3) != 0));
            for (int q = 0; q < 4; q++) begin
                base = 32'(q) << 30;
                for (int k = 0; k < 9; k++) begin
                    logic [31:0] off;
                    case (k)
                        0: off = 0;          1: off = 1023;
                        2: off = 1024;       3: off = 2047;
                        4: off = 2048;       5: off = 3071;
                        6: off = 4095;       7: off = 4096;
                        default: off = (k == 8) ? 32'h00FF_FFFF : 0;
                    endcase
                    mem_addr = base + off; #1;
                    chk("R7 win_hit", win_hit, exp_win(2'(v), mem_addr));
                    chk("R8 sp_hit", sp_hit, exp_sp(4'(v), mem_addr));
                end
                mem_addr = base + 32'h0100_0000; #1;
                chk("R7 win end", win_hit, 0);
            end
        end

        // R10 read-modify-write
        io_write(16'h0023, 8'h02);
        io_read(16'h0023, rd);
        io_write(16'h0023, rd | 8'h0C);
        io_read(16'h0023, rd);
        chk("R10 rmw", rd, 8'h0E);
        chk("R10 sp_size", sp_size, 3);

        // R5 index persists over repeated accesses
        io_write(16'h0023, 8'h05);
        io_write(16'h0023, 8'h09);
        io_read(16'h0023, rd);
        io_read(16'h0023, rd);
        chk("R5 persist", rd, 8'h09);

        // R4 other index
        io_write(16'h0022, 8'hB9);
        io_read(16'h0023, rd);
        chk("R4 other read", rd, 8'h00);
        io_write(16'h0023, 8'h0F);
        chk("R4 sp_size kept", sp_size, 2);
        chk("R4 win_en kept", win_en, 1);
        io_write(16'h0022, 8'hB8);
        io_read(16'h0023, rd);
        chk("R4 cfg kept", rd, 8'h09);

        // R6 index port read and foreign ports
        io_read(16'h0022, rd);
        chk("R6 index read", rd, 8'h00);
        io_write(16'h0024, 8'h0F);
        io_write(16'h0123, 8'h0F);
        io_read(16'h0024, rd);
        chk("R6 foreign read", rd, 8'h00);
        io_read(16'h0023, rd);
        chk("R6 cfg unchanged", rd, 8'h09);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule